// File: doc/BRIEF.md
# Multi-line reservation monitor

This unit supervises one extended linked-load / conditional-store sequence on the core side of a private cache. Each linked load records the address of its cache line in a small reservation table. Repeated links to a line already in the table reuse its entry. Snooped remote writes or invalidations that reach a reserved line break the sequence. A conditional commit never changes control flow. It returns a one-cycle done pulse and a pass/fail bit, and software loops on that bit until it reads a pass.

The unit counts failed commits that come one after another. Once the count reaches a threshold, the next commit does not resolve at once. The unit first takes a cache lock on every reserved line, one line at a time, lowest line address first. Each lock waits for its grant before the next request goes out. Because every core takes its locks in the same address order, two cores cannot wait on each other's lines in a cycle. When all locks are held, the unit reports the result and releases the locks with a single pulse. A link that would need a fifth distinct line is a programming error. It raises an exception pulse and is not treated as a retryable failure. The unit saves no recovery state. The cache it locks into needs at least as many ways as the table has entries.

Top module: `resv_monitor`

## Requirements
- R1: The table holds up to MAX_LINES (default 4) distinct line addresses. A link to a line already reserved takes no new entry, so four distinct lines can be reserved after any number of repeated links to them.
- R2: When the table is full, a link (req_op 2'b01) to a new distinct line leaves the table unchanged and pulses link_fault for exactly one cycle, in the cycle after the request. It does not fail the sequence and produces no done pulse.
- R3: Outside ordered mode, a commit (req_op 2'b10) produces done high for one cycle, in the cycle after the request. commit_ok is 1 only if a sequence is open and no snoop hit it. The sequence then closes. commit_ok is 0 whenever done is low.
- R4: A snoop whose line matches a reserved line that is not locked fails the current sequence, and the failure stays until the sequence closes. A snoop in the same cycle as the commit counts. A snoop to any other line has no effect. The first link after the table is closed opens a new sequence with no failure.
- R5: ordered_mode is high while the number of consecutive failed commits is at least FAIL_LIMIT (default 3). The count saturates at FAIL_LIMIT. Any successful commit clears it. A commit with no open sequence counts as a failure.
- R6: A commit in ordered mode raises busy and requests locks one line at a time, in strictly ascending line address. lock_req and lock_line stay unchanged until lock_gnt is seen high.
- R7: A snoop to a line that is already locked has no effect on the result.
- R8: Once every reserved line is locked, the next cycle ends busy. That same cycle brings done, commit_ok, and a one-cycle lock_release.
- R9: A clear (req_op 2'b11) closes the sequence without a done pulse. During the lock phase it also ends busy and pulses lock_release in the next cycle.
- R10: While busy is high, link and commit requests are ignored.
- R11: After reset, every output is low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 2 | 01 link, 10 commit, 11 clear, 00 none |
| req_line | input | LINE_AW | Line address of a link |
| snp_valid | input | 1 | Remote write or invalidation strobe |
| snp_line | input | LINE_AW | Snooped line address |
| lock_req | output | 1 | Cache lock request for lock_line |
| lock_line | output | LINE_AW | Line to lock, lowest not-yet-locked reserved line |
| lock_gnt | input | 1 | Cache grant for the current lock request |
| lock_release | output | 1 | One-cycle pulse that frees all held locks |
| busy | output | 1 | Ordered lock phase in progress |
| done | output | 1 | One-cycle commit completion pulse |
| commit_ok | output | 1 | Commit result, valid with done |
| link_fault | output | 1 | One-cycle exception on a link beyond the line limit |
| ordered_mode | output | 1 | Next commit will use ordered locking |

## Verification
The case that is hardest to reach from the ports is a snoop that arrives in the middle of an ordered lock phase. It must fail the sequence if it hits a line whose lock is not yet granted, and it must be ignored if it hits a line already granted. Reaching that case needs three failed commits in a row, then a commit, then control over the grant timing. The stimulus fails commits on an empty table to reach ordered mode quickly. It then links lines in descending order and holds lock_gnt low, so the snoop lands on a chosen unlocked or locked line. A long random phase with a small address pool and random grants adds overlaps of faults, merges, clears and lock phases.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LINK   = 2'b01,
    OP_COMMIT = 2'b10,
    OP_CLEAR  = 2'b11
  } resv_op_e;

endpackage

// File: rtl/resv_table.sv
module resv_table #(
  parameter int unsigned LINES = 4,
  parameter int unsigned AW    = 26,
  localparam int unsigned IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      add_en,
  input  logic [AW-1:0]             add_line,
  input  logic                      lock_en,
  input  logic [IW-1:0]             lock_idx,
  input  logic [AW-1:0]             snp_line,
  output logic [LINES-1:0]          cand,
  output logic [LINES-1:0][AW-1:0]  lines,
  output logic                      add_match,
  output logic                      full,
  output logic                      empty,
  output logic                      snp_hit
);

  logic [LINES-1:0]         val_q, val_d;
  logic [LINES-1:0]         lk_q, lk_d;
  logic [LINES-1:0][AW-1:0] line_q;
  logic [LINES-1:0]         hit_add, hit_snp, we;
  logic [IW-1:0]            free_idx;
  logic                     add_ok;
  logic                     dup_seen;

  for (genvar g = 0; g < LINES; g++) begin : g_ent
    assign hit_add[g] = val_q[g] && (line_q[g] == add_line);
    assign hit_snp[g] = val_q[g] && !lk_q[g] && (line_q[g] == snp_line);
    assign we[g]      = add_ok && (free_idx == IW'(g));
  end

  assign add_match = |hit_add;
  assign snp_hit   = |hit_snp;
  assign full      = &val_q;
  assign empty     = ~|val_q;
  assign add_ok    = add_en && !add_match && !full && !clr_all;
  assign cand      = val_q & ~lk_q;
  assign lines     = line_q;

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!val_q[i]) free_idx = IW'(i);
    end
  end

  always_comb begin
    val_d = val_q;
    lk_d  = lk_q;
    if (clr_all) begin
      val_d = '0;
      lk_d  = '0;
    end else begin
      val_d = val_q | we;
      if (lock_en) lk_d[lock_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      lk_q  <= '0;
    end else begin
      val_q <= val_d;
      lk_q  <= lk_d;
    end
  end

  // address storage: written only through its slot enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (we[i]) line_q[i] <= add_line;
    end
  end

  always_comb begin
    dup_seen = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      for (int j = i + 1; j < LINES; j++) begin
        if (val_q[i] && val_q[j] && (line_q[i] == line_q[j])) dup_seen = 1'b1;
      end
    end
  end

  AST_NO_DUP_LINES: assert property (@(posedge clk) disable iff (!rst_n) !dup_seen); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (add_en && full && !add_match && !clr_all) |=> (val_q == $past(val_q))); // R2
  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n) ((lk_q & ~val_q) == '0)); // R7

endmodule

// File: rtl/resv_pick.sv
module resv_pick #(
  parameter int unsigned LINES = 4,
  parameter int unsigned AW    = 26,
  localparam int unsigned IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0]         cand,
  input  logic [LINES-1:0][AW-1:0] lines,
  output logic                     any,
  output logic [IW-1:0]            idx,
  output logic [AW-1:0]            line
);

  // selection of the smallest candidate line: one pass per lock step
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    line = '0;
    for (int i = 0; i < LINES; i++) begin
      if (cand[i] && (!any || (lines[i] < line))) begin
        any  = 1'b1;
        idx  = IW'(i);
        line = lines[i];
      end
    end
  end

endmodule

// File: rtl/resv_progress.sv
module resv_progress #(
  parameter int unsigned FAIL_LIMIT = 3,
  localparam int unsigned CW        = $clog2(FAIL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic result_en,
  input  logic result_ok,
  output logic escalate
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (result_en) begin
      if (result_ok)                       cnt_d = '0;
      else if (cnt_q != CW'(FAIL_LIMIT))   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (result_en) cnt_q <= cnt_d;
  end

  assign escalate = (cnt_q >= CW'(FAIL_LIMIT));

  AST_SUCCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (result_en && result_ok) |=> !escalate); // R5
  AST_MODE_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n) $rose(escalate) |-> $past(result_en && !result_ok)); // R5

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int unsigned LINE_AW    = 26,
  parameter int unsigned MAX_LINES  = 4,
  parameter int unsigned FAIL_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [LINE_AW-1:0] req_line,
  input  logic               snp_valid,
  input  logic [LINE_AW-1:0] snp_line,
  output logic               lock_req,
  output logic [LINE_AW-1:0] lock_line,
  input  logic               lock_gnt,
  output logic               lock_release,
  output logic               busy,
  output logic               done,
  output logic               commit_ok,
  output logic               link_fault,
  output logic               ordered_mode
);

  localparam int unsigned IW = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic busy_q, busy_d;
  logic fail_q, fail_d;
  logic done_q, done_d;
  logic ok_q, ok_d;
  logic fault_q, fault_d;
  logic rel_q, rel_d;

  resv_op_e op;
  logic     clear_req, link_req, commit_req;
  logic     escalate;
  logic     snp_hit, fail_now;

  logic [MAX_LINES-1:0]              tbl_cand;
  logic [MAX_LINES-1:0][LINE_AW-1:0] tbl_lines;
  logic                              tbl_match, tbl_full, tbl_empty, tbl_snp_hit;
  logic                              tbl_clr, tbl_lock_en;
  logic                              pick_any;
  logic [IW-1:0]                     pick_idx;
  logic [LINE_AW-1:0]                pick_line;

  assign op         = resv_op_e'(req_op);
  assign clear_req  = req_valid && (op == OP_CLEAR);
  assign link_req   = req_valid && (op == OP_LINK)   && !busy_q;
  assign commit_req = req_valid && (op == OP_COMMIT) && !busy_q;

  resv_table #(
    .LINES (MAX_LINES),
    .AW    (LINE_AW)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr_all   (tbl_clr),
    .add_en    (link_req),
    .add_line  (req_line),
    .lock_en   (tbl_lock_en),
    .lock_idx  (pick_idx),
    .snp_line  (snp_line),
    .cand      (tbl_cand),
    .lines     (tbl_lines),
    .add_match (tbl_match),
    .full      (tbl_full),
    .empty     (tbl_empty),
    .snp_hit   (tbl_snp_hit)
  );

  resv_pick #(
    .LINES (MAX_LINES),
    .AW    (LINE_AW)
  ) u_pick (
    .cand  (tbl_cand),
    .lines (tbl_lines),
    .any   (pick_any),
    .idx   (pick_idx),
    .line  (pick_line)
  );

  resv_progress #(
    .FAIL_LIMIT (FAIL_LIMIT)
  ) u_progress (
    .clk       (clk),
    .rst_n     (rst_ni),
    .result_en (done_d),
    .result_ok (ok_d),
    .escalate  (escalate)
  );

  assign tbl_lock_en = busy_q && pick_any && lock_gnt && !clear_req;
  assign snp_hit     = snp_valid && tbl_snp_hit;
  assign fail_now    = fail_q || snp_hit;

  always_comb begin
    busy_d  = busy_q;
    fail_d  = fail_now;
    done_d  = 1'b0;
    ok_d    = 1'b0;
    fault_d = 1'b0;
    rel_d   = 1'b0;
    tbl_clr = 1'b0;
    if (clear_req) begin
      busy_d  = 1'b0;
      fail_d  = 1'b0;
      rel_d   = busy_q;
      tbl_clr = 1'b1;
    end else if (busy_q) begin
      if (!pick_any) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        ok_d    = !tbl_empty && !fail_now;
        rel_d   = 1'b1;
        fail_d  = 1'b0;
        tbl_clr = 1'b1;
      end
    end else if (link_req) begin
      if (tbl_empty)                    fail_d  = 1'b0;
      else if (!tbl_match && tbl_full)  fault_d = 1'b1;
    end else if (commit_req) begin
      if (escalate) begin
        busy_d = 1'b1;
      end else begin
        done_d  = 1'b1;
        ok_d    = !tbl_empty && !fail_now;
        fail_d  = 1'b0;
        tbl_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
      ok_q    <= ok_d;
      fault_q <= fault_d;
      rel_q   <= rel_d;
    end
  end

  assign lock_req     = busy_q && pick_any;
  assign lock_line    = pick_line;
  assign lock_release = rel_q;
  assign busy         = busy_q;
  assign done         = done_q;
  assign commit_ok    = ok_q;
  assign link_fault   = fault_q;
  assign ordered_mode = escalate;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_ni) (lock_req && !lock_gnt && !clear_req) |=> (lock_req && $stable(lock_line))); // R6
  AST_LOCK_ASCEND: assert property (@(posedge clk) disable iff (!rst_ni) (lock_req && lock_gnt && !clear_req) |=> (!lock_req || (lock_line > $past(lock_line)))); // R6
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_ni) busy |-> !done); // R10
  AST_RELEASE_ENDS_PHASE: assert property (@(posedge clk) disable iff (!rst_ni) lock_release |-> (!busy && $past(busy))); // R9
  AST_FAULT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_ni) link_fault |-> !done); // R2
  AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_ni) commit_ok |-> done); // R3

endmodule

// File: tb/tb_resv_monitor.sv
module tb_resv_monitor;

  localparam int  CLK_PERIOD = 10;
  localparam int  AW         = 26;
  localparam int  NL         = 4;
  localparam int  LIM        = 3;
  localparam logic [1:0] C_NONE   = 2'b00;
  localparam logic [1:0] C_LINK   = 2'b01;
  localparam logic [1:0] C_COMMIT = 2'b10;
  localparam logic [1:0] C_CLEAR  = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_line;
  logic          snp_valid;
  logic [AW-1:0] snp_line;
  logic          lock_req;
  logic [AW-1:0] lock_line;
  logic          lock_gnt;
  logic          lock_release, busy, done, commit_ok, link_fault, ordered_mode;

  int total = 0;
  int bad   = 0;

  // reference state
  logic [AW-1:0] m_ln [NL];
  bit            m_lk [NL];
  int            m_n;
  bit            m_fail;
  int            m_cnt;
  bit            m_busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resv_monitor #(
    .LINE_AW    (AW),
    .MAX_LINES  (NL),
    .FAIL_LIMIT (LIM)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_line     (req_line),
    .snp_valid    (snp_valid),
    .snp_line     (snp_line),
    .lock_req     (lock_req),
    .lock_line    (lock_line),
    .lock_gnt     (lock_gnt),
    .lock_release (lock_release),
    .busy         (busy),
    .done         (done),
    .commit_ok    (commit_ok),
    .link_fault   (link_fault),
    .ordered_mode (ordered_mode)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_min(output int idx, output bit any, output logic [AW-1:0] ln);
    any = 0; idx = 0; ln = '0;
    for (int i = 0; i < m_n; i++) begin
      if (!m_lk[i] && (!any || m_ln[i] < ln)) begin
        any = 1; idx = i; ln = m_ln[i];
      end
    end
  endtask

  task automatic model_result(input bit ok);
    if (ok) m_cnt = 0;
    else if (m_cnt < LIM) m_cnt++;
  endtask

  task automatic model_close();
    m_n = 0; m_fail = 0;
    for (int i = 0; i < NL; i++) m_lk[i] = 0;
  endtask

  // one cycle: drive at the falling edge, check after the rising edge
  task automatic step(input string tag, input logic v, input logic [1:0] op, input logic [AW-1:0] ln,
                      input logic sv, input logic [AW-1:0] sl, input logic g);
    bit            e_req, any, hit, dup, e_done, e_ok, e_fault, e_rel;
    int            mi;
    logic [AW-1:0] e_line;
    req_valid = v; req_op = op; req_line = ln;
    snp_valid = sv; snp_line = sl; lock_gnt = g;
    #1;
    model_min(mi, any, e_line);
    e_req = m_busy && any;
    chk(tag, "lock_req", 32'(lock_req), 32'(e_req));
    if (e_req) chk(tag, "lock_line", 32'(lock_line), 32'(e_line));
    hit = 0;
    for (int i = 0; i < m_n; i++) if (sv && m_ln[i] == sl && !m_lk[i]) hit = 1;
    e_done = 0; e_ok = 0; e_fault = 0; e_rel = 0;
    if (v && op == C_CLEAR) begin
      e_rel = m_busy; m_busy = 0; model_close();
    end else if (m_busy) begin
      m_fail = m_fail | hit;
      if (!e_req) begin
        e_done = 1; e_ok = (m_n > 0) && !m_fail; e_rel = 1;
        m_busy = 0; model_close(); model_result(e_ok);
      end else if (g) begin
        m_lk[mi] = 1;
      end
    end else if (v && op == C_LINK) begin
      if (m_n == 0) begin
        m_fail = 0; m_ln[0] = ln; m_n = 1;
      end else begin
        m_fail = m_fail | hit;
        dup = 0;
        for (int i = 0; i < m_n; i++) if (m_ln[i] == ln) dup = 1;
        if (!dup) begin
          if (m_n < NL) begin m_ln[m_n] = ln; m_n++; end
          else e_fault = 1;
        end
      end
    end else if (v && op == C_COMMIT) begin
      m_fail = m_fail | hit;
      if (m_cnt >= LIM) m_busy = 1;
      else begin
        e_done = 1; e_ok = (m_n > 0) && !m_fail;
        model_close(); model_result(e_ok);
      end
    end else begin
      m_fail = m_fail | hit;
    end
    @(posedge clk);
    #1;
    chk(tag, "done",         32'(done),         32'(e_done));
    chk(tag, "commit_ok",    32'(commit_ok),    32'(e_ok));
    chk(tag, "link_fault",   32'(link_fault),   32'(e_fault));
    chk(tag, "lock_release", 32'(lock_release), 32'(e_rel));
    chk(tag, "busy",         32'(busy),         32'(m_busy));
    chk(tag, "ordered_mode", 32'(ordered_mode), 32'(m_cnt >= LIM));
    @(negedge clk);
  endtask

  task automatic lnk(input string tag, input logic [AW-1:0] ln);
    step(tag, 1'b1, C_LINK, ln, 1'b0, '0, 1'b0);
  endtask
  task automatic cmt(input string tag);
    step(tag, 1'b1, C_COMMIT, '0, 1'b0, '0, 1'b0);
  endtask
  task automatic snp(input string tag, input logic [AW-1:0] sl);
    step(tag, 1'b0, C_NONE, '0, 1'b1, sl, 1'b0);
  endtask
  task automatic drain(input string tag);
    while (m_busy) step(tag, 1'b0, C_NONE, '0, 1'b0, '0, 1'(($urandom % 2)));
  endtask
  task automatic force_ordered(input string tag);
    while (m_cnt < LIM) cmt(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired, run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20220822));
    rst_n = 1'b0; req_valid = 0; req_op = C_NONE; req_line = '0;
    snp_valid = 0; snp_line = '0; lock_gnt = 0;
    m_n = 0; m_fail = 0; m_cnt = 0; m_busy = 0;
    for (int i = 0; i < NL; i++) begin m_lk[i] = 0; m_ln[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", "lock_req",     32'(lock_req),     0);
    chk("R11", "done",         32'(done),         0);
    chk("R11", "commit_ok",    32'(commit_ok),    0);
    chk("R11", "link_fault",   32'(link_fault),   0);
    chk("R11", "lock_release", 32'(lock_release), 0);
    chk("R11", "busy",         32'(busy),         0);
    chk("R11", "ordered_mode", 32'(ordered_mode), 0);

    // R1: repeated links merge, four distinct lines fit
    lnk("R1", 26'h0A0); lnk("R1", 26'h0A0); lnk("R1", 26'h0B0);
    lnk("R1", 26'h0C0); lnk("R1", 26'h0A0); lnk("R1", 26'h0D0);
    cmt("R3");

    // R2: fifth distinct line faults, table untouched (snoop to it is harmless)
    lnk("R2", 26'h011); lnk("R2", 26'h022); lnk("R2", 26'h033); lnk("R2", 26'h044);
    lnk("R2", 26'h055);
    snp("R2", 26'h055);
    lnk("R2", 26'h022);
    cmt("R2");

    // R4: hit on a reserved line fails, sticky across cycles
    lnk("R4", 26'h100); lnk("R4", 26'h200);
    snp("R4", 26'h200);
    step("R4", 1'b0, C_NONE, '0, 1'b0, '0, 1'b0);
    cmt("R4");
    // R4: a miss has no effect; a new sequence starts clean
    lnk("R4", 26'h100); snp("R4", 26'h300); cmt("R4");
    // R4: hit in the commit cycle counts
    lnk("R4", 26'h100);
    step("R4", 1'b1, C_COMMIT, '0, 1'b1, 26'h100, 1'b0);

    // R3: commit with no open sequence fails
    cmt("R3");

    // R5: consecutive failures reach ordered mode
    force_ordered("R5");

    // R6 / R7 / R8: descending links, locks must come ascending
    lnk("R6", 26'h040); lnk("R6", 26'h030); lnk("R6", 26'h010); lnk("R6", 26'h020);
    cmt("R6");
    step("R6", 1'b0, C_NONE, '0, 1'b0, '0, 1'b0);
    step("R6", 1'b0, C_NONE, '0, 1'b0, '0, 1'b1);
    snp("R7", 26'h010);
    step("R10", 1'b1, C_LINK, 26'h001, 1'b0, '0, 1'b1);
    step("R10", 1'b1, C_COMMIT, '0, 1'b0, '0, 1'b0);
    drain("R8");

    // R4 in the lock phase: snoop an unlocked line before its grant
    force_ordered("R5");
    lnk("R4", 26'h005); lnk("R4", 26'h009);
    cmt("R4");
    step("R4", 1'b0, C_NONE, '0, 1'b1, 26'h009, 1'b0);
    drain("R8");

    // R9: clear aborts the lock phase with a release and no done
    lnk("R9", 26'h077); lnk("R9", 26'h066);
    cmt("R9");
    step("R9", 1'b0, C_NONE, '0, 1'b0, '0, 1'b1);
    step("R9", 1'b1, C_CLEAR, '0, 1'b0, '0, 1'b1);
    step("R9", 1'b0, C_NONE, '0, 1'b0, '0, 1'b0);
    // R9: clear outside the lock phase just closes the sequence
    lnk("R9", 26'h012);
    step("R9", 1'b1, C_CLEAR, '0, 1'b0, '0, 1'b0);
    snp("R9", 26'h012);

    // R5: a successful ordered commit leaves ordered mode
    lnk("R5", 26'h123);
    cmt("R5");
    drain("R5");

    // random mix over a small address pool
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [1:0] op;
      r  = int'($urandom % 100);
      op = (r < 45) ? C_LINK : (r < 65) ? C_COMMIT : (r < 70) ? C_CLEAR : C_NONE;
      step("R5", 1'b1, op, AW'(26'h100 + ($urandom % 6)),
           1'(($urandom % 100) < 12), AW'(26'h100 + ($urandom % 6)), 1'(($urandom % 2)));
    end
    drain("R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule